// File: doc/BRIEF.md
# Flash Data-Polling Completion Checker

This block runs on the host side of a parallel NOR flash. Once a program or erase command has been written to the flash, the block works out whether that operation has finished. It is started with two values: a polling address that the operation covers, and the byte the host expects to find there. For an erase, that byte is all ones. The block then reads the flash over a simple request/acknowledge read bus until the status bit shows the expected value. It reports a pass or a fail verdict.

The status bit is the most significant data bit (STATUS_BIT, 7 by default). While the operation is running, the flash returns that bit inverted. The time-limit flag is bit TIMEOUT_BIT (5 by default). When the flag is set, the status bit may have changed at the same moment, so the block reads the address once more before it decides. The other data bits can settle later than the status bit. For that reason, once the status bit matches, the block issues one further read and presents that byte as the final data. An optional limit on the number of polls forces a fail, so that a bus that never changes cannot hold the block forever.

For a sector erase, the polling address is any address in a sector being erased. For a chip erase, it is any address in an unprotected sector.

Top module: `nor_poll_checker`

## Requirements
- R1: A start pulse taken while the block is not busy latches the address and the expected byte. On the cycle after that pulse, `rd_req_o` is high and `rd_addr_o` carries the latched address. `busy_o` is then high until the verdict.
- R2: Once a read is requested, `rd_req_o` and `rd_addr_o` stay unchanged until a cycle in which `rd_ack_i` is high. `rd_data_i` is sampled in that cycle. `rd_req_o` is low in the following cycle.
- R3: A polled byte is a match when bit 7 of the byte equals bit 7 of the expected byte. After a match the block makes exactly one more read, then reports pass, and `data_o` holds the byte from that last read.
- R4: A polled byte that is not a match and has bit 5 clear causes another poll of the same address.
- R5: A polled byte that is not a match but has bit 5 set causes one re-read. If the re-read matches, the block goes on to the capture read and reports pass.
- R6: If the re-read after a set bit 5 does not match, the block reports fail, and `data_o` holds the re-read byte.
- R7: When the expected byte is 0xFF (erase), completion is recognised when bit 7 reads 1, whatever value the lower bits have.
- R8: With the limit enabled, the block reports fail after POLL_LIMIT consecutive poll reads that all mismatch with bit 5 clear. `data_o` then holds the last byte read, and no further read is requested.
- R9: A start pulse while `busy_o` is high has no effect: the address, the expected byte, the sequence of reads and the verdict stay the same.
- R10: `done_o` rises two clock edges after the edge that takes the final acknowledge. `done_o` then stays high, with exactly one of `pass_o` and `fail_o` high, until the next accepted start. `busy_o` and `done_o` are never high together.
- R11: After reset, `busy_o`, `done_o`, `pass_o`, `fail_o` and `rd_req_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a completion check |
| addr_i | input | AW | Polling address |
| expect_i | input | DW | Expected final byte (all ones for erase) |
| busy_o | output | 1 | Check in progress |
| done_o | output | 1 | Verdict available |
| pass_o | output | 1 | Operation completed |
| fail_o | output | 1 | Operation failed or poll limit exceeded |
| data_o | output | DW | Captured byte, valid while done_o is high |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read acknowledge, data valid in the same cycle |
| rd_data_i | input | DW | Read data |

## Verification
The first request is due one edge after the start pulse is taken. The verdict is due two edges after the edge that takes the final acknowledge: one register holds the read result, and the state machine register makes the second. The bench records the cycle index of every acknowledge it drives. It then compares the cycle in which `done_o` is first seen against that index plus two. All sampling happens on falling edges, so the registered outputs have settled by then. The number of reads issued is checked exactly in every scenario, so a missing or extra re-read or capture read shows up even when the verdict is correct.

// File: rtl/nor_poll_pkg.sv
package nor_poll_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_POLL  = 3'd1,
      ST_RECHK = 3'd2,
      ST_CAPT  = 3'd3,
      ST_DONE  = 3'd4
   } poll_state_e;

   typedef enum logic [1:0] {
      VERD_NONE = 2'd0,
      VERD_PASS = 2'd1,
      VERD_FAIL = 2'd2
   } verdict_e;

endpackage

// File: rtl/npc_bus_reader.sv
module npc_bus_reader #(
   parameter int AW = 20,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          first_i,
   input  logic          again_i,
   input  logic [AW-1:0] addr_i,
   input  logic          rd_ack_i,
   input  logic [DW-1:0] rd_data_i,
   output logic          rd_req_o,
   output logic [AW-1:0] rd_addr_o,
   output logic          rdone_o,
   output logic [DW-1:0] rdata_o
);

   logic          req_q;
   logic [AW-1:0] addr_q;
   logic          rdone_q;
   logic [DW-1:0] rdata_q;
   logic          handshake;

   assign handshake = req_q && rd_ack_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q   <= 1'b0;
         addr_q  <= '0;
         rdone_q <= 1'b0;
         rdata_q <= '0;
      end else begin
         rdone_q <= handshake;
         if (handshake) begin
            rdata_q <= rd_data_i;
         end
         if (first_i) begin
            req_q  <= 1'b1;
            addr_q <= addr_i;
         end else if (again_i) begin
            req_q  <= 1'b1;
         end else if (handshake) begin
            req_q  <= 1'b0;
         end
      end
   end

   assign rd_req_o  = req_q;
   assign rd_addr_o = addr_q;
   assign rdone_o   = rdone_q;
   assign rdata_o   = rdata_q;

endmodule

// File: rtl/npc_poll_limiter.sv
module npc_poll_limiter #(
   parameter bit LIMIT_EN   = 1'b1,
   parameter int POLL_LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic miss_i,
   output logic expired_o
);

   localparam int CNT_W = $clog2(POLL_LIMIT + 1);

   generate
      if (LIMIT_EN) begin : g_limit
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (clear_i) begin
               cnt_q <= '0;
            end else if (miss_i) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign expired_o = miss_i && (cnt_q == CNT_W'(POLL_LIMIT - 1));
      end else begin : g_nolimit
         logic unused_in;
         assign unused_in = clk ^ rst_n ^ clear_i ^ miss_i;
         assign expired_o = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/npc_poll_fsm.sv
module npc_poll_fsm
   import nor_poll_pkg::*;
#(
   parameter int DW          = 8,
   parameter int STATUS_BIT  = 7,
   parameter int TIMEOUT_BIT = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [DW-1:0] expect_i,
   input  logic          rdone_i,
   input  logic [DW-1:0] rdata_i,
   input  logic          expired_i,
   output logic          first_o,
   output logic          again_o,
   output logic          miss_o,
   output logic          clear_o,
   output logic          busy_o,
   output logic          done_o,
   output logic          pass_o,
   output logic          fail_o,
   output logic [DW-1:0] data_o
);

   poll_state_e   state_q, state_d;
   verdict_e      verd_q, verd_d;
   logic [DW-1:0] exp_q;
   logic [DW-1:0] data_q;
   logic          capture;
   logic          accept;
   logic          match;
   logic          tflag;

   assign accept = start_i && ((state_q == ST_IDLE) || (state_q == ST_DONE));
   assign match  = (rdata_i[STATUS_BIT] == exp_q[STATUS_BIT]);
   assign tflag  = rdata_i[TIMEOUT_BIT];

   always_comb begin
      state_d = state_q;
      verd_d  = verd_q;
      first_o = 1'b0;
      again_o = 1'b0;
      miss_o  = 1'b0;
      capture = 1'b0;
      unique case (state_q)
         ST_IDLE, ST_DONE: begin
            if (accept) begin
               first_o = 1'b1;
               verd_d  = VERD_NONE;
               state_d = ST_POLL;
            end
         end
         ST_POLL: begin
            if (rdone_i) begin
               if (match) begin
                  again_o = 1'b1;
                  state_d = ST_CAPT;
               end else if (tflag) begin
                  again_o = 1'b1;
                  state_d = ST_RECHK;
               end else begin
                  miss_o = 1'b1;
                  if (expired_i) begin
                     capture = 1'b1;
                     verd_d  = VERD_FAIL;
                     state_d = ST_DONE;
                  end else begin
                     again_o = 1'b1;
                  end
               end
            end
         end
         ST_RECHK: begin
            if (rdone_i) begin
               if (match) begin
                  again_o = 1'b1;
                  state_d = ST_CAPT;
               end else begin
                  capture = 1'b1;
                  verd_d  = VERD_FAIL;
                  state_d = ST_DONE;
               end
            end
         end
         ST_CAPT: begin
            if (rdone_i) begin
               capture = 1'b1;
               verd_d  = VERD_PASS;
               state_d = ST_DONE;
            end
         end
         default: begin
            state_d = ST_IDLE;
            verd_d  = VERD_NONE;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         verd_q  <= VERD_NONE;
         exp_q   <= '0;
         data_q  <= '0;
      end else begin
         state_q <= state_d;
         verd_q  <= verd_d;
         if (accept) begin
            exp_q <= expect_i;
         end
         if (capture) begin
            data_q <= rdata_i;
         end
      end
   end

   assign clear_o = accept;
   assign busy_o  = (state_q == ST_POLL) || (state_q == ST_RECHK) || (state_q == ST_CAPT);
   assign done_o  = (state_q == ST_DONE);
   assign pass_o  = done_o && (verd_q == VERD_PASS);
   assign fail_o  = done_o && (verd_q == VERD_FAIL);
   assign data_o  = data_q;

endmodule

// File: rtl/nor_poll_checker.sv
module nor_poll_checker #(
   parameter int AW          = 20,
   parameter int DW          = 8,
   parameter int STATUS_BIT  = 7,
   parameter int TIMEOUT_BIT = 5,
   parameter bit LIMIT_EN    = 1'b1,
   parameter int POLL_LIMIT  = 1000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] expect_i,
   output logic          busy_o,
   output logic          done_o,
   output logic          pass_o,
   output logic          fail_o,
   output logic [DW-1:0] data_o,
   output logic          rd_req_o,
   output logic [AW-1:0] rd_addr_o,
   input  logic          rd_ack_i,
   input  logic [DW-1:0] rd_data_i
);

   generate
      if (DW <= STATUS_BIT) begin : g_bad_status
         $error("nor_poll_checker: STATUS_BIT outside data width");
      end
      if (DW <= TIMEOUT_BIT || TIMEOUT_BIT == STATUS_BIT) begin : g_bad_tflag
         $error("nor_poll_checker: TIMEOUT_BIT invalid");
      end
      if (LIMIT_EN && POLL_LIMIT < 1) begin : g_bad_limit
         $error("nor_poll_checker: POLL_LIMIT must be at least 1");
      end
      if (AW < 1) begin : g_bad_aw
         $error("nor_poll_checker: AW must be positive");
      end
   endgenerate

   logic          first_s;
   logic          again_s;
   logic          miss_s;
   logic          clear_s;
   logic          expired_s;
   logic          rdone_s;
   logic [DW-1:0] rdata_s;

   npc_bus_reader #(
      .AW (AW),
      .DW (DW)
   ) u_reader (
      .clk       (clk),
      .rst_n     (rst_n),
      .first_i   (first_s),
      .again_i   (again_s),
      .addr_i    (addr_i),
      .rd_ack_i  (rd_ack_i),
      .rd_data_i (rd_data_i),
      .rd_req_o  (rd_req_o),
      .rd_addr_o (rd_addr_o),
      .rdone_o   (rdone_s),
      .rdata_o   (rdata_s)
   );

   npc_poll_limiter #(
      .LIMIT_EN   (LIMIT_EN),
      .POLL_LIMIT (POLL_LIMIT)
   ) u_limiter (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (clear_s),
      .miss_i    (miss_s),
      .expired_o (expired_s)
   );

   npc_poll_fsm #(
      .DW          (DW),
      .STATUS_BIT  (STATUS_BIT),
      .TIMEOUT_BIT (TIMEOUT_BIT)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .expect_i  (expect_i),
      .rdone_i   (rdone_s),
      .rdata_i   (rdata_s),
      .expired_i (expired_s),
      .first_o   (first_s),
      .again_o   (again_s),
      .miss_o    (miss_s),
      .clear_o   (clear_s),
      .busy_o    (busy_o),
      .done_o    (done_o),
      .pass_o    (pass_o),
      .fail_o    (fail_o),
      .data_o    (data_o)
   );

endmodule

// File: rtl/nor_poll_checker_sva.sv
module nor_poll_checker_sva #(
   parameter int AW = 20,
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          busy_o,
   input logic          done_o,
   input logic          pass_o,
   input logic          fail_o,
   input logic [DW-1:0] data_o,
   input logic          rd_req_o,
   input logic [AW-1:0] rd_addr_o,
   input logic          rd_ack_i
);

   // R2: request and address held until acknowledged
   a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

   // R2: request withdrawn after handshake
   a_r2_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && rd_ack_i) |=> !rd_req_o);

   // R10: exactly one verdict while done
   a_r10_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $onehot({pass_o, fail_o}));

   // R10: busy and done exclusive
   a_r10_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_o && done_o));

   // R10: verdict and data hold while done and no start
   a_r10_verdict_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> (done_o && $stable(pass_o) && $stable(data_o)));

   // R9: address stable across a busy check
   a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(rd_addr_o));

   // R11: no read requested outside a check
   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !rd_req_o);

   // R6 / R8: a verdict only appears with done
   a_r6_fail_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
      (pass_o || fail_o) |-> done_o);

endmodule

bind nor_poll_checker nor_poll_checker_sva #(.AW(AW), .DW(DW)) u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .pass_o    (pass_o),
   .fail_o    (fail_o),
   .data_o    (data_o),
   .rd_req_o  (rd_req_o),
   .rd_addr_o (rd_addr_o),
   .rd_ack_i  (rd_ack_i)
);

// File: tb/nor_poll_checker_tb_top.sv
module nor_poll_checker_tb_top;

   localparam int AW    = 20;
   localparam int DW    = 8;
   localparam int LIMIT = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic [DW-1:0] expect_i = '0;
   logic          busy_o, done_o, pass_o, fail_o;
   logic [DW-1:0] data_o;
   logic          rd_req_o;
   logic [AW-1:0] rd_addr_o;
   logic          rd_ack_i = 1'b0;
   logic [DW-1:0] rd_data_i = '0;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit finished = 1'b0;

   // responder state
   logic [DW-1:0] resp [0:15];
   int            nresp = 0;
   logic [DW-1:0] fill = '0;
   int            lat = 0;
   int            wait_cnt = 0;
   int            ptr = 0;
   int            ack_cyc = 0;
   logic [AW-1:0] exp_addr = '0;
   int            addr_err = 0;

   nor_poll_checker #(
      .AW         (AW),
      .DW         (DW),
      .POLL_LIMIT (LIMIT)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .addr_i    (addr_i),
      .expect_i  (expect_i),
      .busy_o    (busy_o),
      .done_o    (done_o),
      .pass_o    (pass_o),
      .fail_o    (fail_o),
      .data_o    (data_o),
      .rd_req_o  (rd_req_o),
      .rd_addr_o (rd_addr_o),
      .rd_ack_i  (rd_ack_i),
      .rd_data_i (rd_data_i)
   );

   always #10 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // bus responder
   initial begin
      forever begin
         @(negedge clk);
         if (rd_req_o && !rd_ack_i) begin
            if (wait_cnt >= lat) begin
               if (rd_addr_o != exp_addr) addr_err++;
               rd_ack_i  = 1'b1;
               rd_data_i = (ptr < nresp) ? resp[ptr] : fill;
               ptr++;
               ack_cyc  = cyc;
               wait_cnt = 0;
            end else begin
               wait_cnt++;
            end
         end else begin
            rd_ack_i = 1'b0;
         end
      end
   end

   task automatic load_resp(input logic [DW-1:0] b0, input logic [DW-1:0] b1,
                            input logic [DW-1:0] b2, input logic [DW-1:0] b3,
                            input int n, input logic [DW-1:0] f, input int l);
      resp[0] = b0; resp[1] = b1; resp[2] = b2; resp[3] = b3;
      nresp = n; fill = f; lat = l; ptr = 0; wait_cnt = 0; addr_err = 0;
   endtask

   task automatic kick(input logic [AW-1:0] a, input logic [DW-1:0] e);
      @(negedge clk);
      exp_addr = a;
      addr_i   = a;
      expect_i = e;
      start_i  = 1'b1;
      @(negedge clk);
      start_i  = 1'b0;
      check(rd_req_o && rd_addr_o == a, "R1", "first request/address",
            int'(rd_addr_o), int'(a));
      check(busy_o && !done_o, "R1", "busy after start", int'(busy_o), 1);
   endtask

   task automatic wait_done(input string req);
      int n = 0;
      while (!done_o && n < 2000) begin
         @(negedge clk);
         n++;
      end
      check(done_o, req, "done reached", int'(done_o), 1);
      check(cyc == ack_cyc + 2, "R10", "verdict latency", cyc - ack_cyc, 2);
   endtask

   task automatic expect_result(input string req, input bit exp_pass,
                                input logic [DW-1:0] exp_data, input int exp_reads);
      check(pass_o == exp_pass && fail_o == !exp_pass, req, "verdict",
            int'({pass_o, fail_o}), int'({exp_pass, !exp_pass}));
      check(data_o == exp_data, req, "captured data", int'(data_o), int'(exp_data));
      check(ptr == exp_reads, req, "read count", ptr, exp_reads);
      check(addr_err == 0, "R2", "address at acknowledge", addr_err, 0);
      check(!busy_o && !rd_req_o, "R10", "quiet after verdict",
            int'({busy_o, rd_req_o}), 0);
   endtask

   // R3 / R4: program, two polls mismatched with flag clear, then match
   task automatic t_program_pass();
      load_resp(8'h05, 8'h05, 8'h85, 8'hA5, 4, 8'hEE, 2);
      kick(20'h1_2345, 8'hA5);
      wait_done("R3");
      expect_result("R4", 1'b1, 8'hA5, 4);
      repeat (3) @(negedge clk);
      check(done_o && pass_o && data_o == 8'hA5, "R10", "verdict held",
            int'(data_o), 8'hA5);
   endtask

   // R7: erase, low bits differ on the matching poll
   task automatic t_erase_pass();
      load_resp(8'h00, 8'h00, 8'h80, 8'hFF, 4, 8'hEE, 0);
      kick(20'h0_8000, 8'hFF);
      wait_done("R7");
      expect_result("R7", 1'b1, 8'hFF, 4);
   endtask

   // R5: flag set, re-read matches
   task automatic t_flag_then_pass();
      load_resp(8'hA0, 8'h3C, 8'h3C, 8'h00, 3, 8'hEE, 1);
      kick(20'h7_0001, 8'h3C);
      wait_done("R5");
      expect_result("R5", 1'b1, 8'h3C, 3);
   endtask

   // R6: flag set, re-read still mismatched
   task automatic t_flag_then_fail();
      load_resp(8'h20, 8'h21, 8'hFF, 8'hFF, 2, 8'hFF, 0);
      kick(20'h3_3333, 8'hFF);
      wait_done("R6");
      expect_result("R6", 1'b0, 8'h21, 2);
   endtask

   // R8: bus never completes
   task automatic t_limit();
      load_resp(8'h11, 8'h11, 8'h11, 8'h11, 4, 8'h11, 0);
      kick(20'h0_0042, 8'hFF);
      wait_done("R8");
      expect_result("R8", 1'b0, 8'h11, LIMIT);
      repeat (5) @(negedge clk);
      check(ptr == LIMIT, "R8", "no read after limit", ptr, LIMIT);
   endtask

   // R3: immediate match, captured byte comes from the extra read
   task automatic t_capture_second();
      load_resp(8'h80, 8'h81, 8'h00, 8'h00, 2, 8'h00, 0);
      kick(20'h0_0100, 8'h80);
      wait_done("R3");
      expect_result("R3", 1'b1, 8'h81, 2);
   endtask

   // R9: start while busy has no effect
   task automatic t_start_ignored();
      load_resp(8'h05, 8'h05, 8'h85, 8'hA5, 4, 8'hEE, 3);
      kick(20'h5_5555, 8'hA5);
      repeat (2) @(negedge clk);
      check(busy_o, "R9", "busy before second start", int'(busy_o), 1);
      addr_i   = 20'h0_0001;
      expect_i = 8'h00;
      start_i  = 1'b1;
      @(negedge clk);
      start_i  = 1'b0;
      check(rd_addr_o == 20'h5_5555, "R9", "address kept",
            int'(rd_addr_o), 20'h5_5555);
      wait_done("R9");
      expect_result("R9", 1'b1, 8'hA5, 4);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!busy_o && !done_o && !pass_o && !fail_o && !rd_req_o, "R11",
            "reset outputs", int'({busy_o, done_o, pass_o, fail_o, rd_req_o}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!busy_o && !done_o && !rd_req_o, "R11", "idle after reset",
            int'({busy_o, done_o, rd_req_o}), 0);
      t_program_pass();
      t_erase_pass();
      t_flag_then_pass();
      t_flag_then_fail();
      t_limit();
      t_capture_second();
      t_start_ignored();
      repeat (4) @(negedge clk);
      finish_run();
   end

   initial begin
      #(20 * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule